// File: doc/BRIEF.md
# Secure Access Filter with Fault Capture

This block sits on the path from an upstream bus port to a downstream memory and decides, for every access, whether the access may reach the memory. The protected range is split into equal power-of-two blocks. Each block has one bit in an external security bitmap, which is read through a combinational word port. A bit of 1 marks the block as non-secure and a bit of 0 marks it as secure. An access passes only when its own security state matches the bit of the block it targets.

A blocked access is answered locally and never reaches the downstream side. It returns zero read data. A control input selects whether it completes normally or with a bus error. The first blocked access after the status is cleared latches the faulting address, the master ID, the access's non-secure flag and the block's bitmap bit. It then sets a sticky status bit that drives a level interrupt, gated by an enable input. Later blocked accesses leave the captured record untouched until software clears the status. Register decoding lies outside the block: control, enable and clear arrive as plain inputs, and the capture registers are brought out as outputs.

Top module: `sec_access_filter`

## Requirements
- R1: For address A, the block number is A / BLK_BYTES. The bitmap word index driven on `map_idx_o` is the block number / 32, and the bit used is bit (block number mod 32) of `map_word_i`.
- R2: An access passes when the block's bitmap bit equals the access's non-secure state (non-secure = 1). Otherwise it is blocked.
- R3: An access with `up_unspec_i` = 1 is treated as secure whatever `up_secure_i` is, including the non-secure flag it records on a fault.
- R4: A passing access drives `dn_valid_o`, `dn_write_o`, `dn_addr_o` and `dn_wdata_o` from the upstream request. It returns `dn_rdata_i`, `dn_err_i` and `dn_ready_i` on the upstream side in the same cycle.
- R5: A blocked access, read or write, keeps `dn_valid_o` at 0, returns `up_rdata_o` = 0 and completes with `up_ready_o` = 1.
- R6: A blocked access returns `up_err_o` = 1 when `resp_err_i` = 1 and `up_err_o` = 0 when `resp_err_i` = 0.
- R7: A blocked access accepted while `stat_o` = 0 loads `info_addr_o` with its address. It loads `info_attr_o` with bit 17 = the bitmap bit, bit 16 = the non-secure flag and bits 15:0 = the master ID, and it sets `stat_o` at that clock edge. Passing accesses never set `stat_o`.
- R8: While `stat_o` = 1, further blocked accesses change neither `info_addr_o` nor `info_attr_o`.
- R9: `irq_o` is 1 exactly when `stat_o` = 1 and `irq_en_i` = 1.
- R10: `stat_clr_i` clears `stat_o` at the next edge, and a blocked access in the same cycle is not captured. When `stat_o` is already 0, a blocked access in that cycle is captured regardless of `stat_clr_i`.
- R11: After reset, `stat_o`, `info_addr_o`, `info_attr_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Upstream access request |
| up_write_i | input | 1 | Upstream access is a write |
| up_addr_i | input | ADDR_W | Upstream byte address within the protected range |
| up_wdata_i | input | DATA_W | Upstream write data |
| up_secure_i | input | 1 | Access is secure |
| up_unspec_i | input | 1 | Security attribute unspecified (treated as secure) |
| up_mid_i | input | 16 | Requesting master ID |
| up_ready_o | output | 1 | Access completes this cycle |
| up_rdata_o | output | DATA_W | Read data returned upstream |
| up_err_o | output | 1 | Error response returned upstream |
| dn_valid_o | output | 1 | Forwarded access request |
| dn_write_o | output | 1 | Forwarded access is a write |
| dn_addr_o | output | ADDR_W | Forwarded address |
| dn_wdata_o | output | DATA_W | Forwarded write data |
| dn_ready_i | input | 1 | Downstream completes the access |
| dn_rdata_i | input | DATA_W | Downstream read data |
| dn_err_i | input | 1 | Downstream error response |
| map_idx_o | output | IDX_W | Bitmap word index |
| map_word_i | input | 32 | Bitmap word at `map_idx_o` |
| resp_err_i | input | 1 | Blocked accesses return an error when 1 |
| irq_en_i | input | 1 | Interrupt enable |
| stat_clr_i | input | 1 | Clear the fault status |
| stat_o | output | 1 | Fault status (sticky) |
| info_addr_o | output | ADDR_W | Captured fault address |
| info_attr_o | output | 18 | Captured bitmap bit, non-secure flag, master ID |
| irq_o | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle. A blocked request never raises the downstream valid and gets the configured response. A first blocked access sets the status and records its address. The record stays frozen while the status is held. A clear without a capture drops the status, and the interrupt never rises without both status and enable. Only the bench scenarios can show the rest. These are the block and bit mapping across the whole range, the match rule for each security state including unspecified attributes, and the exact captured attribute fields. They also cover the ordering when a clear and a blocked access arrive together.

// File: rtl/sec_filter_pkg.sv
`timescale 1ns/1ps
package sec_filter_pkg;
  localparam int MID_W     = 16;
  localparam int MAP_W     = 32;
  localparam int MAP_SHIFT = 5;

  typedef struct packed {
    logic             cfg_ns;
    logic             nonsec;
    logic [MID_W-1:0] mid;
  } fault_attr_t;

  localparam int ATTR_W = $bits(fault_attr_t);

  function automatic int map_words(int range_b, int blk_b);
    return (range_b / blk_b + MAP_W - 1) / MAP_W;
  endfunction

  function automatic int idx_width(int range_b, int blk_b);
    int n;
    n = map_words(range_b, blk_b);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sec_filter_decode.sv
`timescale 1ns/1ps
module sec_filter_decode #(
  parameter int ADDR_W      = 12,
  parameter int BLK_BYTES   = 32,
  parameter int RANGE_BYTES = 4096,
  parameter int IDX_W       = 2
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           secure_i,
  input  logic                           unspec_i,
  output logic               [IDX_W-1:0] map_idx_o,
  input  logic [sec_filter_pkg::MAP_W-1:0] map_word_i,
  output logic                           cfg_ns_o,
  output logic                           nonsec_o,
  output logic                           pass_o
);
  import sec_filter_pkg::*;

  localparam int BLK_SHIFT = $clog2(BLK_BYTES);
  localparam int WORDS     = map_words(RANGE_BYTES, BLK_BYTES);

  logic [ADDR_W-1:0]    blk_num;
  logic [MAP_SHIFT-1:0] bit_pos;

  assign blk_num = addr_i >> BLK_SHIFT;
  assign bit_pos = blk_num[MAP_SHIFT-1:0];

  generate
    if (WORDS > 1) begin : g_multi_word
      logic [ADDR_W-1:0] word_full;
      assign word_full = blk_num >> MAP_SHIFT;
      assign map_idx_o = word_full[IDX_W-1:0];
    end else begin : g_single_word
      assign map_idx_o = '0;
    end
  endgenerate

  // unspecified attribute counts as secure
  assign nonsec_o = ~(secure_i | unspec_i);
  assign cfg_ns_o = map_word_i[bit_pos];
  assign pass_o   = (cfg_ns_o == nonsec_o);
endmodule

// File: rtl/sec_filter_route.sv
`timescale 1ns/1ps
module sec_filter_route #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  logic              resp_err_i,
  input  logic              up_valid_i,
  input  logic              up_write_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic [DATA_W-1:0] up_wdata_i,
  output logic              up_ready_o,
  output logic [DATA_W-1:0] up_rdata_o,
  output logic              up_err_o,
  output logic              dn_valid_o,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_ready_i,
  input  logic [DATA_W-1:0] dn_rdata_i,
  input  logic              dn_err_i
);
  assign dn_valid_o = up_valid_i & pass_i;
  assign dn_write_o = up_write_i;
  assign dn_addr_o  = up_addr_i;
  assign dn_wdata_o = up_wdata_i;

  always_comb begin
    if (pass_i) begin
      up_ready_o = dn_ready_i;
      up_rdata_o = dn_rdata_i;
      up_err_o   = dn_err_i;
    end else begin
      up_ready_o = 1'b1;
      up_rdata_o = '0;
      up_err_o   = resp_err_i;
    end
  end

  assert_blk_no_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !pass_i) |-> (!dn_valid_o && up_ready_o && up_rdata_o == '0));

  assert_blk_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !pass_i) |-> (up_err_o == resp_err_i));
endmodule

// File: rtl/sec_filter_capture.sv
`timescale 1ns/1ps
module sec_filter_capture #(
  parameter int ADDR_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        blk_i,
  input  logic           [ADDR_W-1:0] addr_i,
  input  sec_filter_pkg::fault_attr_t attr_i,
  input  logic                        clr_i,
  input  logic                        irq_en_i,
  output logic                        stat_o,
  output logic           [ADDR_W-1:0] info_addr_o,
  output sec_filter_pkg::fault_attr_t info_attr_o,
  output logic                        irq_o
);
  import sec_filter_pkg::*;

  logic        stat_q;
  logic        cap_en;
  logic [ADDR_W-1:0] addr_q;
  fault_attr_t attr_q;

  assign cap_en = blk_i & ~stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      addr_q <= '0;
      attr_q <= '0;
    end else begin
      stat_q <= cap_en | (stat_q & ~clr_i);
      if (cap_en) begin
        addr_q <= addr_i;
        attr_q <= attr_i;
      end
    end
  end

  assign stat_o      = stat_q;
  assign info_addr_o = addr_q;
  assign info_attr_o = attr_q;
  assign irq_o       = stat_q & irq_en_i;

  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_i && !stat_o) |=> (stat_o && info_addr_o == $past(addr_i)));

  assert_info_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o |=> ($stable(info_addr_o) && $stable(info_attr_o)));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && stat_o) |=> !stat_o);
endmodule

// File: rtl/sec_access_filter.sv
`timescale 1ns/1ps
module sec_access_filter #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BLK_BYTES   = 32,
  parameter int RANGE_BYTES = 4096,
  localparam int IDX_W      = sec_filter_pkg::idx_width(RANGE_BYTES, BLK_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic              up_write_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic [DATA_W-1:0] up_wdata_i,
  input  logic              up_secure_i,
  input  logic              up_unspec_i,
  input  logic [15:0]       up_mid_i,
  output logic              up_ready_o,
  output logic [DATA_W-1:0] up_rdata_o,
  output logic              up_err_o,
  output logic              dn_valid_o,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_ready_i,
  input  logic [DATA_W-1:0] dn_rdata_i,
  input  logic              dn_err_i,
  output logic [IDX_W-1:0]  map_idx_o,
  input  logic [31:0]       map_word_i,
  input  logic              resp_err_i,
  input  logic              irq_en_i,
  input  logic              stat_clr_i,
  output logic              stat_o,
  output logic [ADDR_W-1:0] info_addr_o,
  output logic [17:0]       info_attr_o,
  output logic              irq_o
);
  import sec_filter_pkg::*;

  logic        cfg_ns;
  logic        nonsec;
  logic        pass;
  fault_attr_t cur_attr;
  fault_attr_t cap_attr;

  sec_filter_decode #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES),
    .RANGE_BYTES(RANGE_BYTES), .IDX_W(IDX_W)
  ) u_decode (
    .addr_i    (up_addr_i),
    .secure_i  (up_secure_i),
    .unspec_i  (up_unspec_i),
    .map_idx_o (map_idx_o),
    .map_word_i(map_word_i),
    .cfg_ns_o  (cfg_ns),
    .nonsec_o  (nonsec),
    .pass_o    (pass)
  );

  sec_filter_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pass_i    (pass),
    .resp_err_i(resp_err_i),
    .up_valid_i(up_valid_i),
    .up_write_i(up_write_i),
    .up_addr_i (up_addr_i),
    .up_wdata_i(up_wdata_i),
    .up_ready_o(up_ready_o),
    .up_rdata_o(up_rdata_o),
    .up_err_o  (up_err_o),
    .dn_valid_o(dn_valid_o),
    .dn_write_o(dn_write_o),
    .dn_addr_o (dn_addr_o),
    .dn_wdata_o(dn_wdata_o),
    .dn_ready_i(dn_ready_i),
    .dn_rdata_i(dn_rdata_i),
    .dn_err_i  (dn_err_i)
  );

  assign cur_attr.cfg_ns = cfg_ns;
  assign cur_attr.nonsec = nonsec;
  assign cur_attr.mid    = up_mid_i;

  sec_filter_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_i      (up_valid_i & ~pass),
    .addr_i     (up_addr_i),
    .attr_i     (cur_attr),
    .clr_i      (stat_clr_i),
    .irq_en_i   (irq_en_i),
    .stat_o     (stat_o),
    .info_addr_o(info_addr_o),
    .info_attr_o(cap_attr),
    .irq_o      (irq_o)
  );

  assign info_attr_o = cap_attr;

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && stat_o));
endmodule

// File: tb/sec_access_filter_tb_top.sv
`timescale 1ns/1ps
module sec_access_filter_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NBLK   = 128;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              up_valid_i = 0, up_write_i = 0, up_secure_i = 0, up_unspec_i = 0;
  logic [ADDR_W-1:0] up_addr_i = '0;
  logic [DATA_W-1:0] up_wdata_i = '0;
  logic [15:0]       up_mid_i = '0;
  logic              up_ready_o, up_err_o;
  logic [DATA_W-1:0] up_rdata_o;
  logic              dn_valid_o, dn_write_o;
  logic [ADDR_W-1:0] dn_addr_o;
  logic [DATA_W-1:0] dn_wdata_o;
  logic              dn_ready_i = 1, dn_err_i = 0;
  logic [DATA_W-1:0] dn_rdata_i;
  logic [1:0]        map_idx_o;
  logic [31:0]       map_word_i;
  logic              resp_err_i = 0, irq_en_i = 1, stat_clr_i = 0;
  logic              stat_o, irq_o;
  logic [ADDR_W-1:0] info_addr_o;
  logic [17:0]       info_attr_o;

  logic [31:0] lut_q [4];
  assign map_word_i = lut_q[map_idx_o];
  assign dn_rdata_i = {20'h5A5A5, dn_addr_o};

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  sec_access_filter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .up_valid_i(up_valid_i), .up_write_i(up_write_i), .up_addr_i(up_addr_i),
    .up_wdata_i(up_wdata_i), .up_secure_i(up_secure_i), .up_unspec_i(up_unspec_i),
    .up_mid_i(up_mid_i), .up_ready_o(up_ready_o), .up_rdata_o(up_rdata_o),
    .up_err_o(up_err_o), .dn_valid_o(dn_valid_o), .dn_write_o(dn_write_o),
    .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_ready_i(dn_ready_i),
    .dn_rdata_i(dn_rdata_i), .dn_err_i(dn_err_i), .map_idx_o(map_idx_o),
    .map_word_i(map_word_i), .resp_err_i(resp_err_i), .irq_en_i(irq_en_i),
    .stat_clr_i(stat_clr_i), .stat_o(stat_o), .info_addr_o(info_addr_o),
    .info_attr_o(info_attr_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive an access at the falling edge and let combinational outputs settle
  task automatic drive(input logic [ADDR_W-1:0] a, input logic wr, input logic sec,
                       input logic un, input logic [15:0] mid, input logic clr);
    @(negedge clk_i);
    up_valid_i = 1; up_write_i = wr; up_addr_i = a; up_secure_i = sec;
    up_unspec_i = un; up_mid_i = mid; up_wdata_i = {20'hC0DE0, a}; stat_clr_i = clr;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    up_valid_i = 0; stat_clr_i = 0;
    #1;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++) lut_q[w] = 32'hA5C3_0F96 ^ (32'h1111_1111 * w);
    repeat (3) @(negedge clk_i);
    #1;
    // R11 reset state
    chk(stat_o == 0 && irq_o == 0, "R11 stat/irq", {stat_o, irq_o}, 0);
    chk(info_addr_o == 0 && info_attr_o == 0, "R11 info", {info_addr_o, info_attr_o[17:0]}, 0);
    rst_ni = 1;

    // sweep: every block, three security modes
    for (int blk = 0; blk < NBLK; blk++) begin
      for (int mode = 0; mode < 3; mode++) begin
        logic [ADDR_W-1:0] a;
        logic cfg, ns, pass, wr;
        a    = ADDR_W'(blk * 32 + ((blk * 7 + mode) % 32));
        cfg  = lut_q[blk / 32][blk % 32];
        ns   = (mode == 1);
        pass = (cfg == ns);
        wr   = blk[0] ^ mode[0];
        resp_err_i = blk[1];
        drive(a, wr, mode == 0, mode == 2, 16'(blk), 1'b1);
        chk(map_idx_o == 2'(blk / 32), "R1 word index", 32'(map_idx_o), blk / 32);
        chk(dn_valid_o == pass, mode == 2 ? "R3 unspecified as secure" : "R2 match rule",
            32'(dn_valid_o), 32'(pass));
        if (pass) begin
          chk(up_rdata_o == {20'h5A5A5, a} && dn_write_o == wr && dn_addr_o == a &&
              dn_wdata_o == {20'hC0DE0, a} && up_err_o == 0 && up_ready_o == 1,
              "R4 forwarded", up_rdata_o, {20'h5A5A5, a});
        end else begin
          chk(up_rdata_o == 0 && up_ready_o == 1, "R5 blocked zero data", up_rdata_o, 0);
          chk(up_err_o == blk[1], "R6 blocked response", 32'(up_err_o), 32'(blk[1]));
        end
      end
    end
    idle();
    resp_err_i = 0;

    // clear leftover status
    @(negedge clk_i); stat_clr_i = 1; #1;
    idle();
    chk(stat_o == 0, "R10 clear", 32'(stat_o), 0);

    // capture scenario: block1 non-secure only, block0 secure only
    lut_q[0] = 32'h0000_0002;
    drive(12'h025, 0, 1, 0, 16'hBEEF, 0);
    chk(dn_valid_o == 0, "R2 secure to ns block", 32'(dn_valid_o), 0);
    idle();
    chk(stat_o == 1 && info_addr_o == 12'h025, "R7 capture addr", {stat_o, 19'd0, info_addr_o}, {1'b1, 19'd0, 12'h025});
    chk(info_attr_o == {1'b1, 1'b0, 16'hBEEF}, "R7 capture attr", 32'(info_attr_o), 32'({1'b1, 1'b0, 16'hBEEF}));
    chk(irq_o == 1, "R9 irq on", 32'(irq_o), 1);

    drive(12'h003, 1, 0, 0, 16'h1234, 0);
    chk(dn_valid_o == 0, "R5 blocked write", 32'(dn_valid_o), 0);
    idle();
    chk(info_addr_o == 12'h025 && info_attr_o == {1'b1, 1'b0, 16'hBEEF}, "R8 frozen",
        32'(info_addr_o), 32'h025);

    irq_en_i = 0; #1;
    chk(irq_o == 0 && stat_o == 1, "R9 irq gated", {irq_o, stat_o}, 32'b01);
    irq_en_i = 1; #1;

    // clear with simultaneous block while status set: clear wins
    drive(12'h003, 0, 0, 0, 16'h1234, 1);
    idle();
    chk(stat_o == 0 && info_addr_o == 12'h025, "R10 clear no capture", {stat_o, 19'd0, info_addr_o}, 32'h025);

    // clear with block while status clear: captured
    drive(12'h007, 0, 0, 0, 16'h0042, 1);
    idle();
    chk(stat_o == 1 && info_addr_o == 12'h007, "R10 capture with clear", {stat_o, 19'd0, info_addr_o}, {1'b1, 19'd0, 12'h007});
    chk(info_attr_o == {1'b0, 1'b1, 16'h0042}, "R7 ns attr", 32'(info_attr_o), 32'({1'b0, 1'b1, 16'h0042}));

    // unspecified attribute fault records non-secure flag 0
    @(negedge clk_i); stat_clr_i = 1; #1;
    idle();
    drive(12'h031, 0, 0, 1, 16'h7777, 0);
    idle();
    chk(info_attr_o == {1'b1, 1'b0, 16'h7777}, "R3 unspecified capture", 32'(info_attr_o), 32'({1'b1, 1'b0, 16'h7777}));

    // passing access does not set status
    @(negedge clk_i); stat_clr_i = 1; #1;
    idle();
    drive(12'h030, 0, 0, 0, 16'h0001, 0);
    chk(dn_valid_o == 1, "R2 ns to ns block", 32'(dn_valid_o), 1);
    idle();
    chk(stat_o == 0, "R7 pass no status", 32'(stat_o), 0);

    // downstream response passthrough
    dn_err_i = 1; dn_ready_i = 0;
    drive(12'h000, 0, 1, 0, 16'h0002, 0);
    chk(up_err_o == 1 && up_ready_o == 0, "R4 downstream resp", {up_err_o, up_ready_o}, 32'b10);
    idle();
    dn_err_i = 0; dn_ready_i = 1;

    // blocked with response bit clear completes OK
    resp_err_i = 0;
    drive(12'h000, 1, 0, 0, 16'h0003, 0);
    chk(up_err_o == 0 && up_ready_o == 1 && up_rdata_o == 0, "R6 blocked ok", {up_err_o, up_ready_o}, 32'b01);
    resp_err_i = 1; #1;
    chk(up_err_o == 1, "R6 blocked err", 32'(up_err_o), 1);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule